// File: doc/BRIEF.md
# Maskable Dual Alarm Comparator

This block watches a running calendar clock held as BCD fields and compares it against two alarm settings. Each alarm setting has one byte per time field. The low seven bits of that byte hold the BCD value to match. The top bit says whether that field takes part in the comparison. A single mechanism therefore covers several kinds of alarm: enabling minute and hour gives a daily alarm, adding the weekday gives a weekly one, and adding date and month gives one alarm per year.

The comparison runs only on the one-second strobe. When every enabled field of an alarm equals the clock, that alarm's status flag is set. The flag stays set until software pulses that alarm's clear strobe. Each alarm also has an interrupt enable. Any set flag whose interrupt enable is high pulls the shared active-low interrupt line low. With its interrupt enable low, an alarm's flag still sets and can be polled.

Top module: `dual_alarm_cmp`

## Requirements
- R1: While reset is high, and on the first cycle after it, both alarm flags are 0 and irq_n is 1.
- R2: Each field occupies one byte of the bus, at byte index 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday. The clock supplies 7-bit BCD values per field. In each alarm byte, bit 7 is the field enable and bits 6:0 are compared with the clock value.
- R3: The comparison happens only at a clock edge where sec_tick is 1. A matching alarm's flag reads 1 from the cycle after that edge. A match present without sec_tick never sets a flag.
- R4: Fields whose enable bit is 0 do not affect the result. This covers the daily (minute+hour), weekly (+weekday) and yearly (+date+month) combinations.
- R5: An alarm whose six enable bits are all 0 never sets its flag, whatever the clock and alarm values.
- R6: A set flag stays 1 until its own flag_clr bit is 1 at an edge, and then reads 0 from the next cycle. The clear for one alarm leaves the other flag unchanged.
- R7: If an alarm matches on sec_tick in the same cycle as its clear strobe, the flag is 1 afterwards.
- R8: irq_n is 0 exactly when some alarm has both its flag and its irq_en bit at 1. The output follows irq_en within the same cycle. A flag with irq_en 0 still reads 1 but does not drive irq_n.
- R9: The two alarms are evaluated independently: a match of one never sets the other's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-second strobe that triggers evaluation |
| time_bcd | input | 42 | Clock fields, 7 bits each, field f at [7f+6:7f] |
| alarm_bcd | input | 96 | Alarm settings, alarm a field f byte at [48a+8f+7:48a+8f] |
| irq_en | input | 2 | Per-alarm interrupt enable |
| flag_clr | input | 2 | Per-alarm flag clear strobe |
| alarm_flag | output | 2 | Sticky per-alarm status flags |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The assertions assume that sec_tick, flag_clr and the register buses are stable across each sampling edge and are only ever 0 or 1 (no unknowns after reset). The bench changes every input one time unit after a falling clock edge, so the rising edge always sees settled values. To produce real matches, the randomized phase draws clock and alarm values from a two-value set. Its enable bits are random too, so all-disabled alarms, clears that coincide with ticks, and toggling interrupt enables all occur. The assertions do not assume that sec_tick is a single-cycle pulse. The bench holds it for one cycle in directed tests and for random lengths in the random phase.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;

    localparam int VAL_BITS  = 7;
    localparam int REG_BITS  = VAL_BITS + 1;
    localparam int EN_BIT    = REG_BITS - 1;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4,
        FLD_WDAY  = 3'd5
    } field_idx_e;

    typedef struct packed {
        logic armed;
        logic hit;
    } alarm_eval_t;

    // One field passes when it is masked out or its value agrees.
    function automatic logic field_pass(input logic [REG_BITS-1:0] areg,
                                        input logic [VAL_BITS-1:0] tval);
        return (!areg[EN_BIT]) || (areg[VAL_BITS-1:0] == tval);
    endfunction

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import dual_alarm_pkg::*;
#(
    parameter int NUM_FIELDS = 6
) (
    input  logic [NUM_FIELDS*REG_BITS-1:0] alarm_reg,
    input  logic [NUM_FIELDS*VAL_BITS-1:0] time_val,
    output alarm_eval_t                    eval
);
    logic [NUM_FIELDS-1:0] pass_vec;
    logic [NUM_FIELDS-1:0] en_vec;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign pass_vec[f] = field_pass(alarm_reg[f*REG_BITS +: REG_BITS],
                                        time_val[f*VAL_BITS +: VAL_BITS]);
        assign en_vec[f]   = alarm_reg[f*REG_BITS + EN_BIT];
    end

    always_comb begin
        eval.armed = |en_vec;
        eval.hit   = eval.armed && (&pass_vec);
    end
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag
    import dual_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        clr,
    input  alarm_eval_t eval,
    output logic        flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (tick && eval.hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int NUM_ALARMS = 2
) (
    input  logic [NUM_ALARMS-1:0] flags,
    input  logic [NUM_ALARMS-1:0] enables,
    output logic                  irq_n
);
    logic [NUM_ALARMS-1:0] routed;

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_route
        assign routed[a] = flags[a] & enables[a];
    end

    assign irq_n = ~(|routed);
endmodule

// File: rtl/dual_alarm_cmp.sv
module dual_alarm_cmp
    import dual_alarm_pkg::*;
#(
    parameter int NUM_FIELDS = 6,
    parameter int NUM_ALARMS = 2
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       sec_tick,
    input  logic [NUM_FIELDS*VAL_BITS-1:0]             time_bcd,
    input  logic [NUM_ALARMS*NUM_FIELDS*REG_BITS-1:0]  alarm_bcd,
    input  logic [NUM_ALARMS-1:0]                      irq_en,
    input  logic [NUM_ALARMS-1:0]                      flag_clr,
    output logic [NUM_ALARMS-1:0]                      alarm_flag,
    output logic                                       irq_n
);
    localparam int SET_BITS = NUM_FIELDS * REG_BITS;

    alarm_eval_t evals [NUM_ALARMS];

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        alarm_match #(.NUM_FIELDS(NUM_FIELDS)) u_match (
            .alarm_reg (alarm_bcd[a*SET_BITS +: SET_BITS]),
            .time_val  (time_bcd),
            .eval      (evals[a])
        );

        alarm_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .tick (sec_tick),
            .clr  (flag_clr[a]),
            .eval (evals[a]),
            .flag (alarm_flag[a])
        );
    end

    irq_merge #(.NUM_ALARMS(NUM_ALARMS)) u_irq (
        .flags   (alarm_flag),
        .enables (irq_en),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/dual_alarm_cmp_chk.sv
module dual_alarm_cmp_chk
    import dual_alarm_pkg::*;
#(
    parameter int NUM_FIELDS = 6,
    parameter int NUM_ALARMS = 2
) (
    input logic                                      clk,
    input logic                                      rst,
    input logic                                      sec_tick,
    input logic [NUM_ALARMS*NUM_FIELDS*REG_BITS-1:0] alarm_bcd,
    input logic [NUM_ALARMS-1:0]                     irq_en,
    input logic [NUM_ALARMS-1:0]                     flag_clr,
    input logic [NUM_ALARMS-1:0]                     alarm_flag,
    input logic                                      irq_n
);
    localparam int SET_BITS = NUM_FIELDS * REG_BITS;

    logic [NUM_ALARMS-1:0] none_enabled;

    always_comb begin
        for (int a = 0; a < NUM_ALARMS; a++) begin
            none_enabled[a] = 1'b1;
            for (int f = 0; f < NUM_FIELDS; f++) begin
                if (alarm_bcd[a*SET_BITS + f*REG_BITS + EN_BIT]) none_enabled[a] = 1'b0;
            end
        end
    end

    // R1: flags cleared on the cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (alarm_flag == '0 && irq_n));

    // R8: irq_n low only with a routed flag
    a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> ($countones(alarm_flag & irq_en) > 0));

    // R8: no interrupt enables means no interrupt
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> irq_n);

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_chk
        // R3: flag rises only after an evaluation tick
        a_r3_set_needs_tick: assert property (@(posedge clk) disable iff (rst)
            (!$past(sec_tick) && !$past(alarm_flag[a])) |-> !alarm_flag[a]);

        // R6: flag stays set without a clear
        a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
            ($past(alarm_flag[a]) && !$past(flag_clr[a])) |-> alarm_flag[a]);

        // R6: clear without tick drops the flag
        a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
            ($past(flag_clr[a]) && !$past(sec_tick) && !$past(rst)) |-> !alarm_flag[a]);

        // R5: all-disabled alarm never rises
        a_r5_no_enable_no_fire: assert property (@(posedge clk) disable iff (rst)
            ($past(none_enabled[a]) && !$past(alarm_flag[a])) |-> !alarm_flag[a]);
    end
endmodule

bind dual_alarm_cmp dual_alarm_cmp_chk #(
    .NUM_FIELDS (NUM_FIELDS),
    .NUM_ALARMS (NUM_ALARMS)
) u_dual_alarm_cmp_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .alarm_bcd  (alarm_bcd),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .alarm_flag (alarm_flag),
    .irq_n      (irq_n)
);

// File: tb/dual_alarm_cmp_bench.sv
`timescale 1ns/1ps
module dual_alarm_cmp_bench;
    localparam int NF = 6;
    localparam int NA = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sec_tick = 1'b0;
    logic [NF*7-1:0]   time_bcd;
    logic [NA*NF*8-1:0] alarm_bcd;
    logic [NA-1:0] irq_en = '0;
    logic [NA-1:0] flag_clr = '0;
    logic [NA-1:0] alarm_flag;
    logic irq_n;

    logic [6:0] tv [NF];
    logic [7:0] av [NA][NF];

    int n_cmp = 0;
    int n_bad = 0;
    bit model_on = 1'b0;
    string phase = "R1";
    logic [NA-1:0] mflag = '0;

    always #4 clk = ~clk;

    always_comb begin
        for (int f = 0; f < NF; f++) time_bcd[f*7 +: 7] = tv[f];
        for (int a = 0; a < NA; a++)
            for (int f = 0; f < NF; f++) alarm_bcd[a*NF*8 + f*8 +: 8] = av[a][f];
    end

    dual_alarm_cmp u_dual_alarm_cmp (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .time_bcd(time_bcd),
        .alarm_bcd(alarm_bcd), .irq_en(irq_en), .flag_clr(flag_clr),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    function automatic bit alarm_hits(int a);
        int enabled = 0;
        bit agree = 1'b1;
        for (int f = 0; f < NF; f++) begin
            if (av[a][f][7]) begin
                enabled++;
                if (av[a][f][6:0] != tv[f]) agree = 1'b0;
            end
        end
        return (enabled > 0) && agree;
    endfunction

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        for (int a = 0; a < NA; a++) begin
            if (rst) mflag[a] <= 1'b0;
            else if (sec_tick && alarm_hits(a)) mflag[a] <= 1'b1;
            else if (flag_clr[a]) mflag[a] <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the reference
    always @(negedge clk) begin
        if (model_on) begin
            bit exp_irq_n;
            exp_irq_n = 1'b1;
            for (int a = 0; a < NA; a++) if (mflag[a] && irq_en[a]) exp_irq_n = 1'b0;
            check(alarm_flag === mflag, phase, "flags vs model", int'(alarm_flag), int'(mflag));
            check(irq_n === exp_irq_n, phase, "irq_n vs model", int'(irq_n), int'(exp_irq_n));
        end
    end

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic pulse_tick();
        sec_tick = 1'b1;
        settle();
        sec_tick = 1'b0;
    endtask

    task automatic clear_flags(input logic [NA-1:0] which);
        flag_clr = which;
        settle();
        flag_clr = '0;
    endtask

    task automatic zero_regs();
        for (int f = 0; f < NF; f++) begin
            tv[f] = 7'h00;
            for (int a = 0; a < NA; a++) av[a][f] = 8'h00;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        zero_regs();
        repeat (3) settle();
        // R1: reset state
        check(alarm_flag == 2'b00, "R1", "flags in reset", int'(alarm_flag), 0);
        check(irq_n == 1'b1, "R1", "irq_n in reset", int'(irq_n), 1);
        rst = 1'b0;
        model_on = 1'b1;
        settle();
        check(alarm_flag == 2'b00, "R1", "flags after reset", int'(alarm_flag), 0);

        // R3: match without tick does nothing, then tick sets
        phase = "R3";
        av[0][0] = 8'h80 | 8'h30; tv[0] = 7'h30;
        repeat (4) settle();
        check(alarm_flag == 2'b00, "R3", "no tick no flag", int'(alarm_flag), 0);
        sec_tick = 1'b1;
        @(posedge clk); #1;
        check(alarm_flag[0] == 1'b1, "R3", "flag after tick edge", int'(alarm_flag[0]), 1);
        @(negedge clk); #1; sec_tick = 1'b0;

        // R6: sticky, own-clear only
        phase = "R6";
        av[1][0] = 8'h80 | 8'h30;
        pulse_tick();
        repeat (3) settle();
        check(alarm_flag == 2'b11, "R6", "both sticky", int'(alarm_flag), 3);
        av[0][0] = 8'h00; av[1][0] = 8'h00;
        clear_flags(2'b01);
        check(alarm_flag == 2'b10, "R6", "clear only alarm0", int'(alarm_flag), 2);
        clear_flags(2'b10);
        check(alarm_flag == 2'b00, "R6", "clear alarm1", int'(alarm_flag), 0);

        // R4: daily alarm ignores disabled fields
        phase = "R4";
        zero_regs();
        av[0][1] = 8'h80 | 8'h15; av[0][2] = 8'h80 | 8'h09;
        av[0][0] = 8'h45; av[0][3] = 8'h12; av[0][5] = 8'h03;
        tv[0] = 7'h07; tv[1] = 7'h15; tv[2] = 7'h09; tv[3] = 7'h28; tv[4] = 7'h11; tv[5] = 7'h06;
        pulse_tick();
        check(alarm_flag == 2'b01, "R4", "daily alarm", int'(alarm_flag), 1);
        clear_flags(2'b01);
        // R4: weekly alarm, weekday must match
        av[0][5] = 8'h80 | 8'h03;
        pulse_tick();
        check(alarm_flag == 2'b00, "R4", "weekly wrong day", int'(alarm_flag), 0);
        tv[5] = 7'h03;
        pulse_tick();
        check(alarm_flag == 2'b01, "R4", "weekly right day", int'(alarm_flag), 1);
        clear_flags(2'b01);
        // R4: yearly alarm with date and month
        av[0][3] = 8'h80 | 8'h28; av[0][4] = 8'h80 | 8'h12;
        pulse_tick();
        check(alarm_flag == 2'b00, "R4", "yearly wrong month", int'(alarm_flag), 0);
        tv[4] = 7'h12;
        pulse_tick();
        check(alarm_flag == 2'b01, "R4", "yearly match", int'(alarm_flag), 1);
        clear_flags(2'b01);

        // R2: value bits compared, enable bit not part of value
        phase = "R2";
        zero_regs();
        av[0][2] = 8'h80 | 8'h21; tv[2] = 7'h20;
        pulse_tick();
        check(alarm_flag == 2'b00, "R2", "hour lsb differs", int'(alarm_flag), 0);
        tv[2] = 7'h21;
        pulse_tick();
        check(alarm_flag == 2'b01, "R2", "hour equal", int'(alarm_flag), 1);
        clear_flags(2'b01);
        av[0][2] = 8'h80 | 8'h61; tv[2] = 7'h21;
        pulse_tick();
        check(alarm_flag == 2'b00, "R2", "bit6 compared", int'(alarm_flag), 0);

        // R5: all enables clear never fires
        phase = "R5";
        zero_regs();
        for (int f = 0; f < NF; f++) begin av[1][f] = 8'h11; tv[f] = 7'h11; end
        repeat (3) pulse_tick();
        check(alarm_flag == 2'b00, "R5", "all disabled", int'(alarm_flag), 0);

        // R9: independence
        phase = "R9";
        av[0][1] = 8'h80 | 8'h11; av[1][1] = 8'h80 | 8'h22;
        pulse_tick();
        check(alarm_flag == 2'b01, "R9", "only alarm0", int'(alarm_flag), 1);

        // R8: interrupt routing
        phase = "R8";
        check(irq_n == 1'b1, "R8", "irq masked", int'(irq_n), 1);
        irq_en = 2'b10;
        #1 check(irq_n == 1'b1, "R8", "wrong enable", int'(irq_n), 1);
        irq_en = 2'b01;
        #1 check(irq_n == 1'b0, "R8", "irq asserted", int'(irq_n), 0);
        clear_flags(2'b01);
        check(irq_n == 1'b1, "R8", "irq released", int'(irq_n), 1);

        // R7: set wins over clear
        phase = "R7";
        pulse_tick();
        sec_tick = 1'b1; flag_clr = 2'b01;
        settle();
        sec_tick = 1'b0; flag_clr = 2'b00;
        check(alarm_flag[0] == 1'b1, "R7", "set beats clear", int'(alarm_flag[0]), 1);
        clear_flags(2'b11);

        // Random phase, compared against the model each clock
        phase = "R4/R6/R7/R8 random";
        for (int i = 0; i < 3000; i++) begin
            for (int f = 0; f < NF; f++) begin
                tv[f] = ($urandom_range(0, 1) != 0) ? 7'h01 : 7'h00;
                for (int a = 0; a < NA; a++)
                    av[a][f] = {($urandom_range(0, 3) == 0), 6'b0, 1'($urandom_range(0, 1))};
            end
            sec_tick = ($urandom_range(0, 2) == 0);
            flag_clr = 2'($urandom_range(0, 3)) & {2{($urandom_range(0, 3) == 0)}};
            irq_en = 2'($urandom_range(0, 3));
            settle();
        end
        sec_tick = 1'b0; flag_clr = '0;
        settle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule